// File: doc/BRIEF.md
# Pointer-Windowed I2C Register Slave

This block is the serial host port of a broadcast-data decoder. It sits on a two-wire bus running at up to 100 kHz. An external controller uses it to reach a 50-entry space at word addresses 0x00 to 0x31. A fast system clock oversamples SCL and SDA, and the block finds START and STOP conditions in those samples. It answers one of two 7-bit bus addresses, chosen by a strap pin. It acknowledges each byte it accepts, and it keeps a word pointer that selects the location each data byte is read from or written to.

The word pointer steps forward after each acknowledged byte, but only inside two windows. The first covers 0x02 to 0x0F and the second covers 0x11 to 0x31. The last address of each window holds the pointer. Locations 0x00, 0x01 and 0x10 never step. Location 0x00 has two meanings. A write sets three control bits. A read returns three live status bits and sends a one-cycle strobe to the flag logic so that it can clear those flags once they are read. Location 0x01 is a write-only interrupt-enable register. Every other location in range is reached through a simple memory port.

Top module: `pdc_i2c_slave`

## Requirements
- R1: The block acknowledges bus address 7'b0010001 when `addr_sel` is 0 and 7'b0010000 when `addr_sel` is 1. Any other address gets no acknowledge, and SDA is not driven for the rest of that transfer.
- R2: After a matched address byte, and after every data byte written by the master, the block holds SDA low for the whole of the ninth SCL clock.
- R3: In a write transfer, the first data byte after the address byte loads the word pointer. Each later byte is register data.
- R4: When the pointer is anywhere from 0x02 to 0x0E, it steps by one after each acknowledged byte. Once it reaches 0x0F, it stays at 0x0F.
- R5: When the pointer is anywhere from 0x11 to 0x30, it steps by one after each acknowledged byte. Once it reaches 0x31, it stays at 0x31.
- R6: When the pointer is 0x00, 0x01 or 0x10, it does not step.
- R7: A write to 0x00 sets `ctrl_iel_o` from data bit 4 and `ctrl_acq_o` from data bits 1:0. A write to 0x01 sets `irq_en_o` from data bits 6:5. Reset clears all three.
- R8: Reading 0x00 returns `{status_i, 5'b00000}`, and `status_rd_o` pulses once for each byte loaded from 0x00. Reading 0x01 returns 0x00.
- R9: In a read transfer, the pointer steps only when the master acknowledges a byte. A master NACK ends the transfer and leaves the pointer where it was.
- R10: The block changes its SDA drive only while SCL is low. SDA is released after reset and after a STOP.
- R11: A data byte written while the pointer is between 0x02 and 0x31 appears on `mem_wdata_o` with a one-cycle `mem_we_o` at `mem_addr_o`. A byte written while the pointer is above 0x31 writes nothing, and a read there returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr_sel | input | 1 | Strap that selects which bus address is answered |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe_o | output | 1 | Pulls SDA low when 1 |
| status_i | input | 3 | Live status bits returned in bits 7:5 of location 0x00 |
| status_rd_o | output | 1 | One-cycle pulse when location 0x00 is loaded for sending |
| ctrl_iel_o | output | 1 | Error-level control bit |
| ctrl_acq_o | output | 2 | Acquisition select bits |
| irq_en_o | output | 2 | Interrupt enables |
| mem_addr_o | output | 6 | Memory port address (the word pointer) |
| mem_rdata_i | input | 8 | Memory read data at `mem_addr_o` |
| mem_we_o | output | 1 | Memory write strobe |
| mem_wdata_o | output | 8 | Memory write data |

## Verification
The bound checker watches four things on every cycle. SDA drive never changes while SCL is high. Memory write strobes only occur at in-range pointers. The status strobe only fires at pointer 0x00. Apart from an explicit load, the pointer either holds or rises by exactly one, and it is pinned at 0x0F, 0x31, 0x00, 0x01 and 0x10. The bus scenarios cover what only a full transfer can show: which address the strap selects, the data and order of burst reads across window ends, NACK leaving the pointer in place, and control writes repeating at a direct address. They also confirm that nothing is written above 0x31.

// File: rtl/pdc_i2c_pkg.sv
package pdc_i2c_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ACK_DRV,
        ST_ACK_HOLD,
        ST_WR,
        ST_RD,
        ST_RD_MACK,
        ST_RD_LOAD
    } bus_st_e;

    localparam int PTR_W  = 8;
    localparam int BYTE_W = 8;

    localparam logic [PTR_W-1:0] A_CTRL    = 8'h00;
    localparam logic [PTR_W-1:0] A_IRQ     = 8'h01;
    localparam logic [PTR_W-1:0] A_WIN0_LO = 8'h02;
    localparam logic [PTR_W-1:0] A_WIN0_HI = 8'h0F;
    localparam logic [PTR_W-1:0] A_WIN1_LO = 8'h11;
    localparam logic [PTR_W-1:0] A_WIN1_HI = 8'h31;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_o,
    output logic sda_o,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);
    typedef struct packed {
        logic [STAGES-1:0] scl_sh;
        logic [STAGES-1:0] sda_sh;
        logic              scl_prev;
        logic              sda_prev;
    } sync_t;

    sync_t d, q;

    always_comb begin
        d          = q;
        d.scl_sh   = {q.scl_sh[STAGES-2:0], scl_i};
        d.sda_sh   = {q.sda_sh[STAGES-2:0], sda_i};
        d.scl_prev = q.scl_sh[STAGES-1];
        d.sda_prev = q.sda_sh[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '1;
        else        q <= d;
    end

    assign scl_o      = q.scl_sh[STAGES-1];
    assign sda_o      = q.sda_sh[STAGES-1];
    assign scl_rise_o = scl_o & ~q.scl_prev;
    assign scl_fall_o = ~scl_o & q.scl_prev;
    assign start_o    = scl_o & q.scl_prev & q.sda_prev & ~sda_o;
    assign stop_o     = scl_o & q.scl_prev & ~q.sda_prev & sda_o;
endmodule

// File: rtl/pdc_ptr_step.sv
module pdc_ptr_step
    import pdc_i2c_pkg::*;
(
    input  logic [PTR_W-1:0] ptr_i,
    output logic [PTR_W-1:0] ptr_next_o
);
    logic in_w0, in_w1;

    always_comb begin
        in_w0      = (ptr_i >= A_WIN0_LO) && (ptr_i < A_WIN0_HI);
        in_w1      = (ptr_i >= A_WIN1_LO) && (ptr_i < A_WIN1_HI);
        ptr_next_o = (in_w0 || in_w1) ? ptr_i + 1'b1 : ptr_i;
    end
endmodule

// File: rtl/pdc_rdata_mux.sv
module pdc_rdata_mux
    import pdc_i2c_pkg::*;
#(
    parameter int STAT_W = 3
) (
    input  logic [PTR_W-1:0]  ptr_i,
    input  logic [STAT_W-1:0] status_i,
    input  logic [BYTE_W-1:0] mem_rdata_i,
    output logic [BYTE_W-1:0] byte_o
);
    localparam int PAD_W = BYTE_W - STAT_W;

    always_comb begin
        if (ptr_i == A_CTRL)        byte_o = {status_i, {PAD_W{1'b0}}};
        else if (ptr_i == A_IRQ)    byte_o = '0;
        else if (ptr_i <= A_WIN1_HI) byte_o = mem_rdata_i;
        else                        byte_o = '0;
    end
endmodule

// File: rtl/pdc_i2c_slave.sv
module pdc_i2c_slave
    import pdc_i2c_pkg::*;
#(
    parameter logic [6:0] BASE_ADDR = 7'h10,
    parameter int         SYNC_STG  = 2,
    parameter int         MEM_AW    = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              addr_sel,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe_o,
    input  logic [2:0]        status_i,
    output logic              status_rd_o,
    output logic              ctrl_iel_o,
    output logic [1:0]        ctrl_acq_o,
    output logic [1:0]        irq_en_o,
    output logic [MEM_AW-1:0] mem_addr_o,
    input  logic [7:0]        mem_rdata_i,
    output logic              mem_we_o,
    output logic [7:0]        mem_wdata_o
);
    localparam int BIT_CW = $clog2(BYTE_W + 1);
    localparam logic [BIT_CW-1:0] LAST_BIT = BIT_CW'(BYTE_W - 1);
    localparam logic [BIT_CW-1:0] ALL_BITS = BIT_CW'(BYTE_W);

    typedef struct packed {
        bus_st_e           st;
        logic [BIT_CW-1:0] bitcnt;
        logic [BYTE_W-1:0] shreg;
        logic [PTR_W-1:0]  ptr;
        logic              first;
        logic              rw;
        logic              oe;
        logic              iel;
        logic [1:0]        acq;
        logic [1:0]        ie;
    } slv_t;

    slv_t d, q;

    logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;
    logic [PTR_W-1:0]  ptr_inc;
    logic [BYTE_W-1:0] tx_byte;
    logic [BYTE_W-1:0] rx_byte;
    logic [6:0]        own_addr;
    logic              ptr_load;
    logic              we_d;
    logic              srd_d;
    logic [PTR_W-1:0]  cur_ptr;

    i2c_line_sync #(.STAGES(SYNC_STG)) sync_i (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_o(scl_lvl), .sda_o(sda_lvl),
        .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
        .start_o(start_det), .stop_o(stop_det)
    );

    pdc_ptr_step step_i (.ptr_i(q.ptr), .ptr_next_o(ptr_inc));

    pdc_rdata_mux #(.STAT_W(3)) rmux_i (
        .ptr_i(q.ptr), .status_i(status_i),
        .mem_rdata_i(mem_rdata_i), .byte_o(tx_byte)
    );

    assign own_addr = BASE_ADDR | {6'b0, ~addr_sel};
    assign rx_byte  = {q.shreg[BYTE_W-2:0], sda_lvl};

    always_comb begin
        d        = q;
        ptr_load = 1'b0;
        we_d     = 1'b0;
        srd_d    = 1'b0;
        unique case (q.st)
            ST_IDLE: ;
            ST_ADDR: if (scl_rise) begin
                d.shreg  = rx_byte;
                d.bitcnt = q.bitcnt + 1'b1;
                if (q.bitcnt == LAST_BIT) begin
                    if (rx_byte[7:1] == own_addr) begin
                        d.rw    = rx_byte[0];
                        d.first = ~rx_byte[0];
                        d.st    = ST_ACK_DRV;
                    end else begin
                        d.st = ST_IDLE;
                    end
                end
            end
            ST_ACK_DRV: if (scl_fall) begin
                d.oe = 1'b1;
                d.st = ST_ACK_HOLD;
            end
            ST_ACK_HOLD: if (scl_fall) begin
                d.oe     = 1'b0;
                d.bitcnt = '0;
                d.st     = ST_WR;
                if (q.rw) begin
                    d.oe     = ~tx_byte[BYTE_W-1];
                    d.shreg  = {tx_byte[BYTE_W-2:0], 1'b0};
                    d.bitcnt = BIT_CW'(1);
                    srd_d    = (q.ptr == A_CTRL);
                    d.st     = ST_RD;
                end
            end
            ST_WR: if (scl_rise) begin
                d.shreg  = rx_byte;
                d.bitcnt = q.bitcnt + 1'b1;
                if (q.bitcnt == LAST_BIT) begin
                    d.st = ST_ACK_DRV;
                    if (q.first) begin
                        d.first  = 1'b0;
                        d.ptr    = rx_byte;
                        ptr_load = 1'b1;
                    end else begin
                        if (q.ptr == A_CTRL) begin
                            d.iel = rx_byte[4];
                            d.acq = rx_byte[1:0];
                        end else if (q.ptr == A_IRQ) begin
                            d.ie = rx_byte[6:5];
                        end else if (q.ptr <= A_WIN1_HI) begin
                            we_d = 1'b1;
                        end
                        d.ptr = ptr_inc;
                    end
                end
            end
            ST_RD: if (scl_fall) begin
                if (q.bitcnt == ALL_BITS) begin
                    d.oe = 1'b0;
                    d.st = ST_RD_MACK;
                end else begin
                    d.oe     = ~q.shreg[BYTE_W-1];
                    d.shreg  = {q.shreg[BYTE_W-2:0], 1'b0};
                    d.bitcnt = q.bitcnt + 1'b1;
                end
            end
            ST_RD_MACK: if (scl_rise) begin
                if (!sda_lvl) begin
                    d.ptr = ptr_inc;
                    d.st  = ST_RD_LOAD;
                end else begin
                    d.st = ST_IDLE;
                end
            end
            ST_RD_LOAD: if (scl_fall) begin
                d.oe     = ~tx_byte[BYTE_W-1];
                d.shreg  = {tx_byte[BYTE_W-2:0], 1'b0};
                d.bitcnt = BIT_CW'(1);
                srd_d    = (q.ptr == A_CTRL);
                d.st     = ST_RD;
            end
            default: d.st = ST_IDLE;
        endcase
        if (start_det) begin
            d.st     = ST_ADDR;
            d.bitcnt = '0;
            d.oe     = 1'b0;
        end else if (stop_det) begin
            d.st = ST_IDLE;
            d.oe = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    assign cur_ptr     = q.ptr;
    assign sda_oe_o    = q.oe;
    assign status_rd_o = srd_d;
    assign ctrl_iel_o  = q.iel;
    assign ctrl_acq_o  = q.acq;
    assign irq_en_o    = q.ie;
    assign mem_addr_o  = q.ptr[MEM_AW-1:0];
    assign mem_we_o    = we_d;
    assign mem_wdata_o = rx_byte;
endmodule

// File: rtl/pdc_i2c_slave_chk.sv
module pdc_i2c_slave_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [7:0] ptr,
    input logic       ptr_load,
    input logic       scl_lvl,
    input logic       sda_oe,
    input logic       mem_we,
    input logic       status_rd
);
    a_r10_sda_quiet_scl_high: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_lvl && $past(scl_lvl)) |-> $stable(sda_oe));

    a_r11_we_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (ptr >= 8'h02 && ptr <= 8'h31));

    a_r8_strobe_at_ctrl: assert property (@(posedge clk) disable iff (!rst_n)
        status_rd |-> (ptr == 8'h00));

    a_r9_ptr_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        !ptr_load |=> (ptr == $past(ptr) || ptr == $past(ptr) + 8'd1));

    a_r4_hold_0f: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr == 8'h0F && !ptr_load) |=> ptr == 8'h0F);

    a_r5_hold_31: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr == 8'h31 && !ptr_load) |=> ptr == 8'h31);

    a_r6_direct_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ((ptr == 8'h00 || ptr == 8'h01 || ptr == 8'h10) && !ptr_load) |=> $stable(ptr));
endmodule

bind pdc_i2c_slave pdc_i2c_slave_chk chk_i (
    .clk(clk), .rst_n(rst_n), .ptr(cur_ptr), .ptr_load(ptr_load),
    .scl_lvl(scl_lvl), .sda_oe(sda_oe_o), .mem_we(mem_we_o),
    .status_rd(status_rd_o)
);

// File: tb/pdc_i2c_slave_tb.sv
module pdc_i2c_slave_tb_top;
    localparam int Q = 20;

    typedef struct packed {
        logic [7:0] start;
        logic [7:0] a0;
        logic [7:0] a1;
        logic [7:0] a2;
    } rv_t;

    localparam rv_t RV [8] = '{
        '{8'h02, 8'h02, 8'h03, 8'h04},
        '{8'h0D, 8'h0D, 8'h0E, 8'h0F},
        '{8'h0E, 8'h0E, 8'h0F, 8'h0F},
        '{8'h0F, 8'h0F, 8'h0F, 8'h0F},
        '{8'h10, 8'h10, 8'h10, 8'h10},
        '{8'h11, 8'h11, 8'h12, 8'h13},
        '{8'h30, 8'h30, 8'h31, 8'h31},
        '{8'h31, 8'h31, 8'h31, 8'h31}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic addr_sel = 1'b0;
    logic scl_drv = 1'b1;
    logic sda_drv = 1'b1;
    logic sda_oe;
    logic sda_line;
    logic [2:0] status = 3'b000;
    logic status_rd;
    logic iel;
    logic [1:0] acq, irq_en;
    logic [5:0] mem_addr;
    logic [7:0] mem_rdata, mem_wdata;
    logic mem_we;
    logic [7:0] bmem [64];
    int n_chk = 0, n_fail = 0, srd_cnt = 0, we_cnt = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;
    assign sda_line  = sda_drv & ~sda_oe;
    assign mem_rdata = bmem[mem_addr];

    pdc_i2c_slave dut_i (
        .clk(clk), .rst_n(rst_n), .addr_sel(addr_sel),
        .scl_i(scl_drv), .sda_i(sda_line), .sda_oe_o(sda_oe),
        .status_i(status), .status_rd_o(status_rd),
        .ctrl_iel_o(iel), .ctrl_acq_o(acq), .irq_en_o(irq_en),
        .mem_addr_o(mem_addr), .mem_rdata_i(mem_rdata),
        .mem_we_o(mem_we), .mem_wdata_o(mem_wdata)
    );

    function automatic logic [7:0] pat(input logic [7:0] a);
        return a ^ 8'h5A;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 64; i++) bmem[i] <= pat(8'(i));
            srd_cnt <= 0;
            we_cnt  <= 0;
        end else begin
            if (mem_we) begin
                bmem[mem_addr] <= mem_wdata;
                we_cnt <= we_cnt + 1;
            end
            if (status_rd) srd_cnt <= srd_cnt + 1;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic w(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_drv = 1'b1; scl_drv = 1'b1; w(Q);
        sda_drv = 1'b0; w(2*Q);
        scl_drv = 1'b0; w(Q);
    endtask

    task automatic bus_stop();
        sda_drv = 1'b0; w(Q);
        scl_drv = 1'b1; w(Q);
        sda_drv = 1'b1; w(2*Q);
    endtask

    task automatic put_bit(input logic b);
        sda_drv = b; w(Q);
        scl_drv = 1'b1; w(2*Q);
        scl_drv = 1'b0; w(Q);
    endtask

    task automatic get_bit(output logic b);
        sda_drv = 1'b1; w(Q);
        scl_drv = 1'b1; w(Q);
        b = sda_line; w(Q);
        scl_drv = 1'b0; w(Q);
    endtask

    task automatic send_byte(input logic [7:0] v, output logic acked);
        logic b;
        for (int i = 7; i >= 0; i--) put_bit(v[i]);
        get_bit(b);
        acked = ~b;
    endtask

    task automatic recv_byte(input logic ack, output logic [7:0] v);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            get_bit(b);
            v[i] = b;
        end
        put_bit(~ack);
        sda_drv = 1'b1;
    endtask

    function automatic logic [7:0] dev_w();
        return addr_sel ? 8'h20 : 8'h22;
    endfunction

    task automatic wr_txn(input logic [7:0] p, input logic [23:0] dat, input int n);
        logic a;
        bus_start();
        send_byte(dev_w(), a);
        send_byte(p, a);
        for (int i = 0; i < n; i++) send_byte(dat[23-8*i -: 8], a);
        bus_stop();
    endtask

    task automatic rd_txn(input int n, output logic [23:0] dat);
        logic a;
        logic [7:0] v;
        dat = '0;
        bus_start();
        send_byte(dev_w() | 8'h01, a);
        for (int i = 0; i < n; i++) begin
            recv_byte(i != n - 1, v);
            dat[23-8*i -: 8] = v;
        end
        bus_stop();
    endtask

    initial begin
        logic ack;
        logic [23:0] rd;
        int base;
        w(5);
        rst_n = 1'b1;
        w(5);
        // R7 R10: state after reset
        chk("R7 iel reset", iel, 0);
        chk("R7 acq reset", acq, 0);
        chk("R7 irq_en reset", irq_en, 0);
        chk("R10 sda released", sda_oe, 0);

        // R1 R2: strap-selected address
        bus_start(); send_byte(8'h22, ack); bus_stop();
        chk("R1 R2 0x11 acked with strap 0", ack, 1);
        bus_start(); send_byte(8'h20, ack); bus_stop();
        chk("R1 0x10 ignored with strap 0", ack, 0);
        chk("R10 released after stop", sda_oe, 0);
        addr_sel = 1'b1; w(4);
        bus_start(); send_byte(8'h20, ack); bus_stop();
        chk("R1 0x10 acked with strap 1", ack, 1);
        bus_start(); send_byte(8'h22, ack); bus_stop();
        chk("R1 0x11 ignored with strap 1", ack, 0);
        addr_sel = 1'b0; w(4);

        // R3 R4 R5 R6 R9: burst read table
        for (int k = 0; k < 8; k++) begin
            wr_txn(RV[k].start, 24'h0, 0);
            rd_txn(3, rd);
            chk("R3 R4 R5 R6 R9 burst byte0", rd[23:16], pat(RV[k].a0));
            chk("R4 R5 R6 R9 burst byte1", rd[15:8], pat(RV[k].a1));
            chk("R4 R5 R6 R9 burst byte2", rd[7:0], pat(RV[k].a2));
        end

        // R9: NACK leaves pointer
        wr_txn(8'h05, 24'h0, 0);
        rd_txn(1, rd);
        chk("R9 first single read", rd[23:16], pat(8'h05));
        rd_txn(1, rd);
        chk("R9 pointer held after NACK", rd[23:16], pat(8'h05));
        rd_txn(2, rd);
        chk("R9 ack advances", rd[15:8], pat(8'h06));

        // R7 R6: control and interrupt enables
        wr_txn(8'h00, 24'hFF0000, 1);
        chk("R7 iel set", iel, 1);
        chk("R7 acq set", acq, 3);
        chk("R7 irq_en untouched", irq_en, 0);
        wr_txn(8'h01, 24'h600000, 1);
        chk("R7 irq_en set", irq_en, 3);
        wr_txn(8'h00, 24'h120100, 2);
        chk("R6 repeated 0x00 write iel", iel, 0);
        chk("R6 repeated 0x00 write acq", acq, 1);
        chk("R6 irq_en kept", irq_en, 3);

        // R8: status read and strobe
        status = 3'b101;
        wr_txn(8'h00, 24'h0, 0);
        base = srd_cnt;
        rd_txn(1, rd);
        chk("R8 status byte", rd[23:16], 8'hA0);
        chk("R8 one strobe", srd_cnt - base, 1);
        base = srd_cnt;
        rd_txn(2, rd);
        chk("R8 R6 direct status reread", rd[15:8], 8'hA0);
        chk("R8 two strobes", srd_cnt - base, 2);
        wr_txn(8'h01, 24'h0, 0);
        rd_txn(1, rd);
        chk("R8 0x01 reads zero", rd[23:16], 8'h00);

        // R4 R11: write burst over first window end
        wr_txn(8'h0E, 24'hAABBCC, 3);
        wr_txn(8'h0E, 24'h0, 0);
        rd_txn(2, rd);
        chk("R11 R4 write 0x0E", rd[23:16], 8'hAA);
        chk("R11 R4 write held at 0x0F", rd[15:8], 8'hCC);
        // R5: second window end
        wr_txn(8'h30, 24'h112233, 3);
        wr_txn(8'h30, 24'h0, 0);
        rd_txn(2, rd);
        chk("R5 write 0x30", rd[23:16], 8'h11);
        chk("R5 write held at 0x31", rd[15:8], 8'h33);
        // R6: gap location direct
        wr_txn(8'h10, 24'h445500, 2);
        wr_txn(8'h10, 24'h0, 0);
        rd_txn(2, rd);
        chk("R6 0x10 last write", rd[23:16], 8'h55);
        chk("R6 0x10 no step", rd[15:8], 8'h55);
        rd_txn(1, rd);
        wr_txn(8'h11, 24'h0, 0);
        rd_txn(1, rd);
        chk("R6 0x11 untouched", rd[23:16], pat(8'h11));
        // R11: out of range
        base = we_cnt;
        wr_txn(8'h35, 24'h770000, 1);
        chk("R11 no write above 0x31", we_cnt - base, 0);
        rd_txn(1, rd);
        chk("R11 read above 0x31", rd[23:16], 8'h00);

        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule